// File: doc/BRIEF.md
# Dual-Write-Port Register File

This block holds the general-purpose registers of a sequential processor core: eight 32-bit registers with two combinational read ports and two clocked write ports. The decode stage presents two source register numbers and receives both operand values in the same cycle. The write-back stage can retire two results in one clock: an ALU result on the E port and a loaded value on the M port. A stack pop needs this, because it writes the new stack pointer (register 4) and the popped value together.

Register number 8 is reserved to mean "no register". A read port given that number returns zero, and a write port given that number changes nothing. Numbers 9 to 15 are treated the same way. When both write ports name the same register in one cycle, the M port's value is the one stored.

Top module: `dual_write_regfile`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), and after it is released, every register reads as zero on both read ports.
- R2: A read port is combinational. A change of rd_a_id or rd_b_id changes the matching data output within the same cycle, with no clock edge.
- R3: A write on the E port (wr_e_id 0..7) stores wr_e_data at the next rising clock edge.
- R4: A write on the M port (wr_m_id 0..7) stores wr_m_data at the next rising clock edge.
- R5: Both write ports can name different registers in the same cycle, and both registers are updated at that edge. An example is register 4 (stack pointer) on E together with another register on M.
- R6: If wr_e_id equals wr_m_id (0..7) in the same cycle, the register takes wr_m_data.
- R7: Before the clock edge, a read of a register that is being written in that cycle returns the old value. The new value appears only after the edge.
- R8: A read port whose ID is 8 or above returns 32'h0.
- R9: A write port whose ID is 8 or above changes no register.
- R10: Both read ports work independently. When both name the same register, they return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears all registers |
| rd_a_id | input | 4 | Register number for read port A (8 and above: idle) |
| rd_a_data | output | 32 | Value for read port A |
| rd_b_id | input | 4 | Register number for read port B (8 and above: idle) |
| rd_b_data | output | 32 | Value for read port B |
| wr_e_id | input | 4 | Destination of the E write (8 and above: idle) |
| wr_e_data | input | 32 | Data for the E write |
| wr_m_id | input | 4 | Destination of the M write (8 and above: idle, wins on collision) |
| wr_m_data | input | 32 | Data for the M write |

## Verification
The bench goes after three cases:
- A collision of E and M on one register. A design with the priority reversed would keep the ALU value and lose the loaded value.
- A pop-style cycle that writes the stack pointer and a second register together. A design with one shared enable would drop one of the two writes.
- The reserved ID 8 on reads and on writes. A design that aliased ID 8 onto register 0 would return live data or corrupt register 0.

The bench also reads a register in the cycle it is written. A design that forwarded the write data, or that latched the data transparently, would show the new value before the edge.

// File: rtl/dwrf_pkg.sv
package dwrf_pkg;
  localparam int unsigned DWRF_DATA_W = 32;
  localparam int unsigned DWRF_NREGS  = 8;
  localparam int unsigned DWRF_SP_REG = 4;
endpackage

// File: rtl/dwrf_write_ctl.sv
module dwrf_write_ctl #(
  parameter int unsigned NREGS = 8,
  parameter int unsigned ID_W  = 4
) (
  input  logic [ID_W-1:0]  e_id,
  input  logic [ID_W-1:0]  m_id,
  output logic [NREGS-1:0] e_hit,
  output logic [NREGS-1:0] m_hit,
  output logic [NREGS-1:0] take_e,
  output logic [NREGS-1:0] take_m
);
  localparam logic [ID_W-1:0] NONE_ID = ID_W'(NREGS);

  logic e_live, m_live;

  function automatic logic id_match(input logic [ID_W-1:0] id, input int unsigned idx);
    return id == ID_W'(idx);
  endfunction

  assign e_live = e_id < NONE_ID;
  assign m_live = m_id < NONE_ID;

  for (genvar i = 0; i < NREGS; i++) begin : g_dec
    assign e_hit[i]  = e_live && id_match(e_id, i);
    assign m_hit[i]  = m_live && id_match(m_id, i);
    // the M port owns a register it names; E only gets the rest
    assign take_m[i] = m_hit[i];
    assign take_e[i] = e_hit[i] && !m_hit[i];
  end
endmodule

// File: rtl/dwrf_cell.sv
module dwrf_cell #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_e,
  input  logic              take_m,
  input  logic [DATA_W-1:0] e_data,
  input  logic [DATA_W-1:0] m_data,
  output logic [DATA_W-1:0] q
);
  function automatic logic [DATA_W-1:0] next_val(
    input logic [DATA_W-1:0] cur,
    input logic te, input logic [DATA_W-1:0] de,
    input logic tm, input logic [DATA_W-1:0] dm);
    if (tm) return dm;
    if (te) return de;
    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= next_val(q, take_e, e_data, take_m, m_data);
  end
endmodule

// File: rtl/dwrf_read_port.sv
module dwrf_read_port #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 8,
  parameter int unsigned ID_W   = 4
) (
  input  logic [ID_W-1:0]               id,
  input  logic [NREGS-1:0][DATA_W-1:0]  regs,
  output logic [DATA_W-1:0]             data
);
  localparam int unsigned     IDX_W   = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [ID_W-1:0] NONE_ID = ID_W'(NREGS);

  logic             live;
  logic [IDX_W-1:0] idx;

  assign live = id < NONE_ID;
  assign idx  = id[IDX_W-1:0];

  always_comb begin
    data = '0;
    if (live) data = regs[idx];
  end
endmodule

// File: rtl/dual_write_regfile.sv
module dual_write_regfile #(
  parameter int unsigned DATA_W = dwrf_pkg::DWRF_DATA_W,
  parameter int unsigned NREGS  = dwrf_pkg::DWRF_NREGS,
  parameter int unsigned ID_W   = $clog2(NREGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   rd_a_id,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ID_W-1:0]   rd_b_id,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic [ID_W-1:0]   wr_e_id,
  input  logic [DATA_W-1:0] wr_e_data,
  input  logic [ID_W-1:0]   wr_m_id,
  input  logic [DATA_W-1:0] wr_m_data
);
  localparam int unsigned     IDX_W   = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [ID_W-1:0] NONE_ID = ID_W'(NREGS);

  logic [NREGS-1:0][DATA_W-1:0] regs;
  logic [NREGS-1:0] e_hit, m_hit, take_e, take_m;

  // named events for the checks below
  logic             wr_e_live, wr_m_live, wr_collide;
  logic [IDX_W-1:0] e_idx, m_idx;

  assign wr_e_live  = wr_e_id < NONE_ID;
  assign wr_m_live  = wr_m_id < NONE_ID;
  assign wr_collide = wr_e_live && wr_m_live && (wr_e_id == wr_m_id);
  assign e_idx      = wr_e_id[IDX_W-1:0];
  assign m_idx      = wr_m_id[IDX_W-1:0];

  dwrf_write_ctl #(.NREGS(NREGS), .ID_W(ID_W)) u_wctl (
    .e_id   (wr_e_id),
    .m_id   (wr_m_id),
    .e_hit  (e_hit),
    .m_hit  (m_hit),
    .take_e (take_e),
    .take_m (take_m)
  );

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    dwrf_cell #(.DATA_W(DATA_W)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .take_e (take_e[i]),
      .take_m (take_m[i]),
      .e_data (wr_e_data),
      .m_data (wr_m_data),
      .q      (regs[i])
    );

    AST_UNTOUCHED_HOLDS : assert property (@(posedge clk) disable iff (!rst_n)
      !(e_hit[i] || m_hit[i]) |=> $stable(regs[i]))
      else $error("register %0d changed without a write", i); // R9
  end

  dwrf_read_port #(.DATA_W(DATA_W), .NREGS(NREGS), .ID_W(ID_W)) u_rd_a (
    .id   (rd_a_id),
    .regs (regs),
    .data (rd_a_data)
  );

  dwrf_read_port #(.DATA_W(DATA_W), .NREGS(NREGS), .ID_W(ID_W)) u_rd_b (
    .id   (rd_b_id),
    .regs (regs),
    .data (rd_b_data)
  );

  AST_E_WRITE_LANDS : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_e_live && !wr_collide) |=> regs[$past(e_idx)] == $past(wr_e_data))
    else $error("E write lost"); // R3

  AST_M_WRITE_LANDS : assert property (@(posedge clk) disable iff (!rst_n)
    wr_m_live |=> regs[$past(m_idx)] == $past(wr_m_data))
    else $error("M write lost or overridden"); // R6

  AST_PORTS_AGREE : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_id == rd_b_id) |-> (rd_a_data == rd_b_data))
    else $error("read ports disagree"); // R10

  AST_IDLE_READ_ZERO : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_id >= NONE_ID) |-> (rd_b_data == '0))
    else $error("idle read not zero"); // R8
endmodule

// File: tb/sim_dual_write_regfile.sv
module sim_dual_write_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_id = 4'd0, rd_b_id = 4'd0, wr_e_id = 4'd8, wr_m_id = 4'd8;
  logic [31:0] wr_e_data = '0, wr_m_data = '0;
  logic [31:0] rd_a_data, rd_b_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_write_regfile u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_a_id(rd_a_id), .rd_a_data(rd_a_data),
    .rd_b_id(rd_b_id), .rd_b_data(rd_b_data),
    .wr_e_id(wr_e_id), .wr_e_data(wr_e_data),
    .wr_m_id(wr_m_id), .wr_m_data(wr_m_data)
  );

  typedef struct {
    bit          port_b;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t       sb[$];
  event        sample_ev;
  int          n_cmp = 0, n_bad = 0;
  logic [31:0] model [8];
  bit          done = 0;

  function automatic logic [31:0] expect_of(input logic [3:0] id);
    return (id < 4'd8) ? model[id[2:0]] : 32'h0;
  endfunction

  // driver side: set read IDs, queue what each port must show
  task automatic probe(input logic [3:0] a, input logic [3:0] b, input string req);
    item_t it;
    rd_a_id = a; rd_b_id = b;
    #1;
    it.port_b = 0; it.exp = expect_of(a); it.req = req; sb.push_back(it);
    it.port_b = 1; it.exp = expect_of(b); it.req = req; sb.push_back(it);
    -> sample_ev;
    #1;
  endtask

  // monitor side: pop and compare
  always @(sample_ev) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb.pop_front();
      act = it.port_b ? rd_b_data : rd_a_data;
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s port %s actual=%h expected=%h", it.req, it.port_b ? "B" : "A", act, it.exp);
      end
    end
  end

  // one write cycle, driven from a negative edge; the model follows the rules
  task automatic wr_cycle(input logic [3:0] eid, input logic [31:0] ed,
                          input logic [3:0] mid, input logic [31:0] md);
    wr_e_id = eid; wr_e_data = ed; wr_m_id = mid; wr_m_data = md;
    @(posedge clk);
    if (eid < 4'd8) model[eid[2:0]] = ed;
    if (mid < 4'd8) model[mid[2:0]] = md;   // M last: it wins
    @(negedge clk);
    wr_e_id = 4'd8; wr_m_id = 4'd8;
  endtask

  task automatic sweep(input string req);
    for (int r = 0; r < 8; r++) probe(4'(r), 4'(7 - r), req);
  endtask

  initial begin
    for (int r = 0; r < 8; r++) model[r] = '0;
    // R1: state under reset
    #3;
    sweep("R1");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R1");

    // R3: E writes into every register
    for (int r = 0; r < 8; r++) begin
      wr_cycle(4'(r), 32'hE000_0000 + 32'(r * 17), 4'd8, '0);
      probe(4'(r), 4'(r), "R3");
    end
    // R4: M writes into every register
    for (int r = 0; r < 8; r++) begin
      wr_cycle(4'd8, '0, 4'(r), 32'hA5A5_0000 ^ 32'(r * 4099));
      probe(4'(r), 4'(r), "R4");
    end

    // R5: pop-like cycle, stack pointer on E, popped value on M
    wr_cycle(4'd4, 32'h0000_1004, 4'd2, 32'hDEAD_BEEF);
    probe(4'd4, 4'd2, "R5");
    wr_cycle(4'd0, 32'h1111_1111, 4'd7, 32'h7777_7777);
    probe(4'd0, 4'd7, "R5");

    // R6: collision, M must win
    wr_cycle(4'd3, 32'hBAD0_0003, 4'd3, 32'h600D_0003);
    probe(4'd3, 4'd3, "R6");
    wr_cycle(4'd0, 32'hBAD0_0000, 4'd0, 32'h600D_0000);
    probe(4'd0, 4'd4, "R6");

    // R7: read during the write cycle shows the old value
    wr_e_id = 4'd5; wr_e_data = 32'h5555_AAAA; wr_m_id = 4'd6; wr_m_data = 32'h6666_BBBB;
    probe(4'd5, 4'd6, "R7");
    @(posedge clk);
    model[5] = 32'h5555_AAAA; model[6] = 32'h6666_BBBB;
    @(negedge clk);
    wr_e_id = 4'd8; wr_m_id = 4'd8;
    probe(4'd5, 4'd6, "R7");

    // R2: read IDs move mid-cycle, outputs follow without an edge
    probe(4'd1, 4'd2, "R2");
    probe(4'd2, 4'd1, "R2");

    // R8: idle read IDs give zero
    probe(4'd8, 4'd8, "R8");
    probe(4'd15, 4'd9, "R8");

    // R9: writes to idle IDs leave all registers alone
    wr_cycle(4'd8, 32'hFFFF_FFFF, 4'd8, 32'hFFFF_FFFF);
    sweep("R9");
    wr_cycle(4'd12, 32'hCCCC_CCCC, 4'd9, 32'h9999_9999);
    sweep("R9");
    // idle E with live M, and live E with idle M
    wr_cycle(4'd8, 32'h0BAD_0BAD, 4'd1, 32'h0101_0101);
    wr_cycle(4'd2, 32'h0202_0202, 4'd14, 32'h0BAD_0BAD);
    sweep("R9");

    // R10: both ports on one register, and a mix
    probe(4'd6, 4'd6, "R10");
    probe(4'd4, 4'd8, "R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule